// File: doc/BRIEF.md
# Link Output Mode Controller

This block decides, every clock, whether the four output drivers of a lane-based signal conditioner are on, and reports which operating mode the link is in. It takes an active-low reset pin, an active-high enable pin, an activity flag from the analog signal detector, and configuration fields from registers: a squelch-bypass bit, a detector threshold select, a lane-count code, a power-down bit and a dwell length. It produces one driver enable per lane, the threshold code for the detector, and a 2-bit mode status.

The mode decision is a four-state machine. The states are SHUTDOWN (status 2'b10), PWRDN (2'b11), OUTDIS (2'b01) and NORMAL (2'b00). Its transitions are: *force-off* (enable low, from any state, to SHUTDOWN); *power-off* (power-down bit set, from any state, to PWRDN); *bypass* (squelch bypassed, from any state, to NORMAL); *wake* (from SHUTDOWN or PWRDN with squelch active, to OUTDIS); *squelch* (NORMAL to OUTDIS when the synchronized activity flag is low); and *qualify* (OUTDIS to NORMAL after enough consecutive active cycles). A low reset pin puts the machine in SHUTDOWN at once. The decisions take effect in this priority order: shutdown, then power-down, then squelch, then the lane mask. The activity flag comes from an analog circuit with no relation to the clock, so it passes through a two-flop synchronizer before the machine uses it.

Top module: `lnk_mode_ctrl`

## Requirements
- R1: A low `rst_n` puts the block at once in SHUTDOWN (status 2'b10) with all driver enables low. With `rst_n` high, `en_i` low at a clock edge gives SHUTDOWN after that edge, whatever the other inputs are.
- R2: The squelch is active when `sq_bypass_i`=0. If the squelch is active, the block is in NORMAL, and the synchronized activity is low at an edge, the block enters OUTDIS (status 2'b01) after that edge, with all driver enables low.
- R3: With `sq_bypass_i`=1, `en_i`=1 and `pwr_down_i`=0, the block is in NORMAL (status 2'b00) after the next edge, whatever the activity input is.
- R4: `det_thr_o` always equals `sq_thr_i`. The codes are 00 for 40 mVpp, 01 for 80 mVpp, 10 for 160 mVpp and 11 for 250 mVpp.
- R5: In NORMAL, the driver enables depend on `lane_cnt_i`. Code 00 enables no lanes, 01 enables lane 0 only (4'b0001), 10 enables lanes 1:0 (4'b0011) and 11 enables all lanes (4'b1111).
- R6: With `en_i`=1 and `pwr_down_i`=1, the block is in PWRDN (status 2'b11) after the next edge, with all driver enables low. This holds whatever the squelch bit and the activity input are.
- R7: `act_i` reaches the decision through two flops. The block leaves OUTDIS at the edge where the synchronized activity has been high on `dwell_i` consecutive edges spent in OUTDIS, counting that edge. A low cycle restarts the count. A `dwell_i` of 0 acts as 1.
- R8: From SHUTDOWN or PWRDN with the squelch active, the block always goes to OUTDIS first and never goes straight to NORMAL.
- R9: Outside NORMAL, all driver enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset pin, asynchronous |
| en_i | input | 1 | Enable pin; low forces shutdown |
| act_i | input | 1 | Activity flag from the analog detector, asynchronous |
| sq_bypass_i | input | 1 | 0 makes the squelch active, 1 bypasses it |
| sq_thr_i | input | 2 | Squelch threshold select |
| lane_cnt_i | input | 2 | Lane-count code |
| pwr_down_i | input | 1 | Register power-down |
| dwell_i | input | DWELL_W | Consecutive active cycles needed to leave OUTDIS |
| drv_en_o | output | NLANES | Per-lane driver enables |
| det_thr_o | output | 2 | Threshold code sent to the detector |
| mode_o | output | 2 | Mode status |

## Verification
The assertions check, on every cycle, the edge-to-edge rules of the mode decision. They cover forced shutdown, power-down with drivers off, squelch bypass, entry into OUTDIS on lost activity, no exit from OUTDIS while activity is low, no direct wake into NORMAL, and no enables when the lane count is zero. Some behaviour needs stimulus sequences and only the bench scenarios can show it. This includes the two-cycle synchronizer latency, the dwell count and its restart after a glitch, treating a dwell of 0 as 1, the full lane-mask table, and the asynchronous reset arriving in the middle of operation. The bench's behavioural model predicts all three outputs, and the bench compares them against the design every cycle.

// File: rtl/lnk_mode_pkg.sv
package lnk_mode_pkg;
    typedef enum logic [1:0] {
        MD_NORMAL   = 2'b00,
        MD_OUTDIS   = 2'b01,
        MD_SHUTDOWN = 2'b10,
        MD_PWRDN    = 2'b11
    } mode_e;
endpackage

// File: rtl/lnk_act_sync.sv
module lnk_act_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/lnk_lane_decode.sv
module lnk_lane_decode #(
    parameter int NLANES = 4
) (
    input  logic [1:0]        code_i,
    output logic [NLANES-1:0] mask_o
);
    int lim;

    always_comb begin
        unique case (code_i)
            2'b00:   lim = 0;
            2'b01:   lim = 1;
            2'b10:   lim = 2;
            default: lim = NLANES;
        endcase
    end

    genvar g;
    generate
        for (g = 0; g < NLANES; g++) begin : g_lane
            assign mask_o[g] = (g < lim);
        end
    endgenerate
endmodule

// File: rtl/lnk_mode_fsm.sv
module lnk_mode_fsm
    import lnk_mode_pkg::*;
#(
    parameter int DWELL_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_i,
    input  logic               pwr_down_i,
    input  logic               sq_bypass_i,
    input  logic               act_s_i,
    input  logic [DWELL_W-1:0] dwell_i,
    output mode_e              state_o
);
    localparam int CW = DWELL_W + 1;
    localparam logic [DWELL_W-1:0] CNT_MAX = {DWELL_W{1'b1}};

    mode_e              state_q, state_d;
    logic [DWELL_W-1:0] run_q, run_d;
    logic [CW-1:0]      need, seen;
    logic               qualified;

    assign need      = (dwell_i == '0) ? CW'(1) : {1'b0, dwell_i};
    assign seen      = {1'b0, run_q} + CW'(1);
    assign qualified = act_s_i && (seen >= need);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MD_SHUTDOWN;
            run_q   <= '0;
        end else begin
            state_q <= state_d;
            run_q   <= run_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (!en_i) begin
            state_d = MD_SHUTDOWN;
        end else if (pwr_down_i) begin
            state_d = MD_PWRDN;
        end else if (sq_bypass_i) begin
            state_d = MD_NORMAL;
        end else begin
            unique case (state_q)
                MD_NORMAL: state_d = act_s_i ? MD_NORMAL : MD_OUTDIS;
                MD_OUTDIS: state_d = qualified ? MD_NORMAL : MD_OUTDIS;
                default:   state_d = MD_OUTDIS;
            endcase
        end
    end

    always_comb begin
        if (state_q == MD_OUTDIS && act_s_i)
            run_d = (run_q == CNT_MAX) ? run_q : run_q + 1'b1;
        else
            run_d = '0;
    end

    assign state_o = state_q;

    AST_SQUELCH_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MD_NORMAL && en_i && !pwr_down_i && !sq_bypass_i && !act_s_i)
        |=> state_q == MD_OUTDIS); // R2
    AST_NO_EARLY_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MD_OUTDIS && en_i && !pwr_down_i && !sq_bypass_i && !act_s_i)
        |=> state_q == MD_OUTDIS); // R7
    AST_WAKE_QUALIFY: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == MD_SHUTDOWN || state_q == MD_PWRDN) && en_i && !pwr_down_i && !sq_bypass_i)
        |=> state_q == MD_OUTDIS); // R8
endmodule

// File: rtl/lnk_mode_ctrl.sv
module lnk_mode_ctrl
    import lnk_mode_pkg::*;
#(
    parameter int NLANES  = 4,
    parameter int DWELL_W = 4,
    parameter int SYNC_N  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_i,
    input  logic               act_i,
    input  logic               sq_bypass_i,
    input  logic [1:0]         sq_thr_i,
    input  logic [1:0]         lane_cnt_i,
    input  logic               pwr_down_i,
    input  logic [DWELL_W-1:0] dwell_i,
    output logic [NLANES-1:0]  drv_en_o,
    output logic [1:0]         det_thr_o,
    output logic [1:0]         mode_o
);
    logic              act_s;
    logic [NLANES-1:0] lane_mask;
    mode_e             state;

    lnk_act_sync #(.STAGES(SYNC_N)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (act_i),
        .sync_o  (act_s)
    );

    lnk_lane_decode #(.NLANES(NLANES)) u_lanes (
        .code_i (lane_cnt_i),
        .mask_o (lane_mask)
    );

    lnk_mode_fsm #(.DWELL_W(DWELL_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (en_i),
        .pwr_down_i  (pwr_down_i),
        .sq_bypass_i (sq_bypass_i),
        .act_s_i     (act_s),
        .dwell_i     (dwell_i),
        .state_o     (state)
    );

    always_comb begin
        unique case (state)
            MD_NORMAL: drv_en_o = lane_mask;
            default:   drv_en_o = '0;
        endcase
    end

    assign det_thr_o = sq_thr_i;
    assign mode_o    = state;

    AST_FORCE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (mode_o == MD_SHUTDOWN && drv_en_o == '0)); // R1
    AST_BYPASS_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !pwr_down_i && sq_bypass_i) |=> mode_o == MD_NORMAL); // R3
    AST_PWR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && pwr_down_i) |=> (mode_o == MD_PWRDN && drv_en_o == '0)); // R6
    AST_ZERO_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_cnt_i == 2'b00) |-> drv_en_o == '0); // R5
endmodule

// File: tb/sim_lnk_mode_ctrl.sv
`timescale 1ns/1ps
module sim_lnk_mode_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_i = 1'b0;
    logic       act_i = 1'b0;
    logic       sq_bypass_i = 1'b0;
    logic [1:0] sq_thr_i = 2'b01;
    logic [1:0] lane_cnt_i = 2'b11;
    logic       pwr_down_i = 1'b0;
    logic [3:0] dwell_i = 4'd3;
    logic [3:0] drv_en_o;
    logic [1:0] det_thr_o;
    logic [1:0] mode_o;

    int    n_checks = 0;
    int    n_fail   = 0;
    int    cycles   = 0;
    string cur_req  = "R1";

    // reference model state: 0 normal, 1 outdis, 2 shutdown, 3 pwrdn
    int m_st  = 2;
    int m_run = 0;
    int m_s1  = 0;
    int m_s2  = 0;

    always #2.5 clk = ~clk;

    lnk_mode_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .act_i(act_i),
        .sq_bypass_i(sq_bypass_i), .sq_thr_i(sq_thr_i), .lane_cnt_i(lane_cnt_i),
        .pwr_down_i(pwr_down_i), .dwell_i(dwell_i),
        .drv_en_o(drv_en_o), .det_thr_o(det_thr_o), .mode_o(mode_o)
    );

    function automatic int exp_mask(input int code);
        if (code == 0) return 0;
        if (code == 1) return 1;
        if (code == 2) return 3;
        return 15;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 2; m_run = 0; m_s1 = 0; m_s2 = 0;
        end else begin
            int nxt;
            int need;
            need = (dwell_i == 0) ? 1 : int'(dwell_i);
            if (!en_i)            nxt = 2;
            else if (pwr_down_i)  nxt = 3;
            else if (sq_bypass_i) nxt = 0;
            else if (m_st == 0)   nxt = (m_s2 != 0) ? 0 : 1;
            else if (m_st == 1)   nxt = (m_s2 != 0 && m_run + 1 >= need) ? 0 : 1;
            else                  nxt = 1;
            if (m_st == 1 && m_s2 != 0) m_run = m_run + 1;
            else                        m_run = 0;
            m_st = nxt;
            m_s2 = m_s1;
            m_s1 = int'(act_i);
        end
    end

    task automatic chk(input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at cycle %0d",
                     cur_req, what, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        chk("mode", int'(mode_o), m_st);
        chk("drv_en", int'(drv_en_o), (m_st == 0) ? exp_mask(int'(lane_cnt_i)) : 0);
        chk("det_thr", int'(det_thr_o), int'(sq_thr_i));
        if (cycles > 100000) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual %0d expected below %0d", cycles, 100000);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    initial begin
        cur_req = "R1";
        step(4);
        rst_n = 1'b1;
        step(3);
        // bypass squelch: straight to NORMAL
        cur_req = "R3";
        en_i = 1'b1; sq_bypass_i = 1'b1;
        step(4);
        cur_req = "R5";
        for (int c = 0; c < 4; c++) begin
            lane_cnt_i = 2'(c);
            step(2);
        end
        cur_req = "R4";
        for (int t = 0; t < 4; t++) begin
            sq_thr_i = 2'(t);
            step(1);
        end
        cur_req = "R6";
        pwr_down_i = 1'b1; act_i = 1'b1;
        step(3);
        cur_req = "R1";
        en_i = 1'b0;
        step(3);
        en_i = 1'b1; pwr_down_i = 1'b0;
        step(2);
        // squelch active, activity present: wake via OUTDIS
        cur_req = "R8";
        sq_bypass_i = 1'b0;
        pwr_down_i = 1'b1;
        step(2);
        pwr_down_i = 1'b0;
        step(6);
        cur_req = "R2";
        act_i = 1'b0;
        step(5);
        cur_req = "R9";
        lane_cnt_i = 2'b10;
        step(2);
        cur_req = "R7";
        act_i = 1'b1; step(2);
        act_i = 1'b0; step(1);
        act_i = 1'b1; step(8);
        act_i = 1'b0; step(4);
        dwell_i = 4'd0;
        act_i = 1'b1; step(4);
        act_i = 1'b0; step(4);
        dwell_i = 4'd7;
        act_i = 1'b1; step(12);
        act_i = 1'b0; step(3);
        dwell_i = 4'd15;
        act_i = 1'b1; step(20);
        cur_req = "R3";
        act_i = 1'b0; sq_bypass_i = 1'b1;
        step(4);
        cur_req = "R1";
        #1 rst_n = 1'b0;
        #1;
        chk("async mode", int'(mode_o), 2);
        chk("async drv_en", int'(drv_en_o), 0);
        step(2);
        rst_n = 1'b1;
        step(4);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule